// File: doc/BRIEF.md
# Dual-Clock FIFO with Standard and Fall-Through Read Timing

This block buffers 18-bit words between a write clock domain and a read clock domain. The two clocks are unrelated. Each may run at any rate, and either may stop. Words leave in the order they arrived. The storage is an inferred register array. Write and read pointers cross between the domains as Gray code through multi-flop synchronizers. The full decision is made in the write domain and the empty decision in the read domain.

The read timing is chosen while master reset is held, and it stays fixed until the next master reset.

- **Standard timing:** a word reaches the output register only on an explicit read. The two flags report "empty" and "full".
- **Fall-through timing:** the oldest stored word is loaded into the output register without a read request. A read request then consumes that word. The flags report "output holds valid data" and "space available".

Three further controls act on the FIFO:

- **Partial reset** empties the FIFO but keeps the selected timing.
- **Rewind** returns the read pointer to location zero so that stored data can be read again.
- **Output enable** forces the data outputs to zero and drops a separate valid indication.

Top module: `twin_clock_fifo`

## Requirements
- R1: A word is stored on each rising `wr_clk` edge where `wr_en_n` is 0 and the FIFO is not full. In standard timing, each rising `rd_clk` edge where `rd_en_n` is 0 and the FIFO is not empty loads the oldest word into the output register.
- R2: The level of `mode_sel` is sampled while `mst_rst_n` is 0. A level of 0 selects standard timing and 1 selects fall-through timing. Later changes of `mode_sel` have no effect until the next master reset.
- R3: In standard timing, `rd_flag`=1 means empty and `wr_flag`=1 means full. A word written into an empty FIFO leaves the output at its previous value until a read is made.
- R4: In fall-through timing, `rd_flag`=1 means the output holds valid data and `wr_flag`=1 means there is space. A word written into an empty FIFO appears on the output on the third rising `rd_clk` edge after the write edge, with no read request.
- R5: In fall-through timing, the displayed word stays on the output while `rd_en_n` is 1. Each `rd_en_n`=0 edge replaces it with the next word, or drops `rd_flag` when no further word is stored.
- R6: A write attempted while full is discarded, and the pointers do not move.
- R7: A standard-timing read attempted while empty is discarded, and the output register keeps its value.
- R8: Master reset (`mst_rst_n`=0) and partial reset (`part_rst_n`=0) both clear both pointers and the output register to zero. Partial reset keeps the timing selected at the last master reset.
- R9: `rt_n`=0 on a rising `rd_clk` edge sets the read pointer to location zero and leaves the write pointer unchanged. For the next cycle the empty indication is forced: `rd_flag`=1 in standard timing and `rd_flag`=0 in fall-through timing. Reads then replay the data from the first word.
- R10: With `out_en`=0, `rd_data` is all zeros and `rd_data_vld` is 0. With `out_en`=1, `rd_data` shows the output register and `rd_data_vld` is 1.
- R11: The order of words is kept with unrelated write and read clock rates.
- R12: The FIFO holds 2^ADDR_W words. In standard timing `wr_flag` rises right after the write that fills the array and falls again once reads have freed space.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write domain clock |
| rd_clk | input | 1 | Read domain clock |
| mst_rst_n | input | 1 | Master reset, active low, synchronous in each domain |
| part_rst_n | input | 1 | Partial reset, active low, keeps the timing choice |
| mode_sel | input | 1 | Timing choice sampled during master reset (0 standard, 1 fall-through) |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | DATA_W | Word to store |
| rd_en_n | input | 1 | Read request, active low |
| rt_n | input | 1 | Rewind request, active low, read domain |
| out_en | input | 1 | Output enable, active high |
| rd_data | output | DATA_W | Output register value, or zero when disabled |
| rd_data_vld | output | 1 | High when `rd_data` carries the output register |
| wr_flag | output | 1 | Full (standard) or space available (fall-through) |
| rd_flag | output | 1 | Empty (standard) or output valid (fall-through) |

## Verification
The assertions check the following rules on every clock edge:

- A full write or an empty standard read leaves the pointers and the output register unchanged.
- Each domain's Gray pointer moves by at most one bit per cycle, apart from a rewind.
- The timing choice stays fixed between master resets, including across partial resets.
- A valid fall-through word stays on the output until a read request or a rewind.
- A rewind forces the empty indication on the next cycle.

Only the directed scenarios can show the remaining behaviour:

- the exact three-edge fall-through latency;
- the data order across a full-depth fill at unrelated clock rates;
- the replay of data after a rewind;
- the output-enable gating;
- the fact that a partial reset keeps fall-through timing.

// File: rtl/tcf_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the dual-clock FIFO.
// Assumes nothing beyond IEEE 1800-2017.
package tcf_pkg;
    // Read timing style latched at master reset.
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FALL = 1'b1
    } tmode_e;
endpackage

// File: rtl/tcf_sync.sv
`timescale 1ns/1ps
// Module: tcf_sync
// Multi-flop synchronizer for a Gray-coded pointer bus. Assumes the input
// changes by at most one bit per source clock, so every sampled value is
// either the old or the new pointer.
module tcf_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift the pointer through the synchronizing flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                stg[i] <= stg[i-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/tcf_mem.sv
`timescale 1ns/1ps
// Module: tcf_mem
// Inferred register-array storage: one synchronous write port in the write
// domain and one asynchronous read port used by the read domain. Assumes the
// read side only addresses locations whose write has already been
// synchronized across.
module tcf_mem #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] cells [DEPTH];

    // Store a word on an accepted write.
    always_ff @(posedge wclk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/tcf_wr_ctrl.sv
`timescale 1ns/1ps
// Module: tcf_wr_ctrl
// Write-domain control: write pointer in binary and Gray form, full
// decision against the synchronized read pointer, timing latch and
// write-side flag. Assumes ADDR_W >= 2 and resets held for several clocks.
module tcf_wr_ctrl
    import tcf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              mst_rst_n,
    input  logic              part_rst_n,
    input  logic              mode_sel,
    input  logic              wr_en_n,
    input  logic [ADDR_W:0]   rgray_s,
    output logic [ADDR_W-1:0] waddr,
    output logic              we,
    output logic [ADDR_W:0]   wgray,
    output logic              wr_flag,
    output tmode_e            mode
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] FULL_XOR = PW'(3) << (ADDR_W - 1);

    logic [PW-1:0] wbin;
    logic [PW-1:0] wbin_nxt;
    logic          full;

    // Full when the pointers differ only in the two top Gray bits.
    assign full     = ((wgray ^ rgray_s) == FULL_XOR);
    assign we       = !wr_en_n && !full;
    assign wbin_nxt = wbin + PW'(1);

    // Advance the write pointer on an accepted write.
    always_ff @(posedge clk) begin
        if (!mst_rst_n || !part_rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we) begin
            wbin  <= wbin_nxt;
            wgray <= wbin_nxt ^ (wbin_nxt >> 1);
        end
    end

    // Latch the timing choice while master reset is held.
    always_ff @(posedge clk) begin
        if (!mst_rst_n) begin
            mode <= tmode_e'(mode_sel);
        end
    end

    assign waddr   = wbin[ADDR_W-1:0];
    assign wr_flag = (mode == MODE_FALL) ? !full : full;
endmodule

// File: rtl/tcf_rd_ctrl.sv
`timescale 1ns/1ps
// Module: tcf_rd_ctrl
// Read-domain control: read pointer, empty decision against the synchronized
// write pointer, output register, standard or fall-through load policy,
// rewind with a one-cycle blanking, and the read-side flag. Assumes a rewind
// is used only while the write pointer has not passed the array depth since
// the last reset.
module tcf_rd_ctrl
    import tcf_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              mst_rst_n,
    input  logic              part_rst_n,
    input  logic              mode_sel,
    input  logic              rd_en_n,
    input  logic              rt_n,
    input  logic [ADDR_W:0]   wgray_s,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic [DATA_W-1:0] q,
    output logic              rd_flag,
    output tmode_e            mode
);
    localparam int PW = ADDR_W + 1;

    logic [PW-1:0] rbin;
    logic [PW-1:0] rbin_nxt;
    logic          mem_empty;
    logic          fall;
    logic          pop;
    logic          rewind;
    logic          rt_blank;
    logic          out_valid;
    logic          rst_any;

    assign rst_any   = !mst_rst_n || !part_rst_n;
    assign fall      = (mode == MODE_FALL);
    assign mem_empty = (rgray == wgray_s);
    assign rewind    = !rt_n;
    assign rbin_nxt  = rbin + PW'(1);
    // Fall-through refills an empty or consumed output; standard waits for a request.
    assign pop = !mem_empty && !rt_blank && !rewind &&
                 (fall ? (!out_valid || !rd_en_n) : !rd_en_n);

    // Move the read pointer: rewind beats an ordinary pop.
    always_ff @(posedge clk) begin
        if (rst_any) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (rewind) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (pop) begin
            rbin  <= rbin_nxt;
            rgray <= rbin_nxt ^ (rbin_nxt >> 1);
        end
    end

    // Hold the empty indication for the cycle after a rewind.
    always_ff @(posedge clk) begin
        if (rst_any) begin
            rt_blank <= 1'b0;
        end else begin
            rt_blank <= rewind;
        end
    end

    // Load the output register with the popped word.
    always_ff @(posedge clk) begin
        if (rst_any) begin
            q <= '0;
        end else if (pop) begin
            q <= mem_rdata;
        end
    end

    // Track whether the output register holds an unconsumed word.
    always_ff @(posedge clk) begin
        if (rst_any || rewind) begin
            out_valid <= 1'b0;
        end else if (pop) begin
            out_valid <= 1'b1;
        end else if (!rd_en_n) begin
            out_valid <= 1'b0;
        end
    end

    // Latch the timing choice while master reset is held.
    always_ff @(posedge clk) begin
        if (!mst_rst_n) begin
            mode <= tmode_e'(mode_sel);
        end
    end

    assign raddr   = rbin[ADDR_W-1:0];
    assign rd_flag = fall ? out_valid : (mem_empty || rt_blank);
endmodule

// File: rtl/twin_clock_fifo.sv
`timescale 1ns/1ps
// Module: twin_clock_fifo
// Dual-clock FIFO top: ties the storage, both domain controllers and the two
// pointer synchronizers together, and gates the data outputs with the output
// enable. Assumes both resets are held across several edges of each clock.
module twin_clock_fifo
    import tcf_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              wr_clk,
    input  logic              rd_clk,
    input  logic              mst_rst_n,
    input  logic              part_rst_n,
    input  logic              mode_sel,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    input  logic              rt_n,
    input  logic              out_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_data_vld,
    output logic              wr_flag,
    output logic              rd_flag
);
    localparam int PW = ADDR_W + 1;

    logic              rst_ok;
    logic [ADDR_W-1:0] waddr_w;
    logic [ADDR_W-1:0] raddr_r;
    logic              we_w;
    logic [PW-1:0]     wgray_w;
    logic [PW-1:0]     rgray_r;
    logic [PW-1:0]     wgray_s;
    logic [PW-1:0]     rgray_s;
    logic [DATA_W-1:0] mem_q;
    logic [DATA_W-1:0] q_r;
    tmode_e            wr_mode_w;
    tmode_e            rd_mode_r;

    assign rst_ok = mst_rst_n && part_rst_n;

    tcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_mem (
        .wclk (wr_clk),
        .we   (we_w),
        .waddr(waddr_w),
        .wdata(wr_data),
        .raddr(raddr_r),
        .rdata(mem_q)
    );

    tcf_wr_ctrl #(.ADDR_W(ADDR_W)) i_wr (
        .clk       (wr_clk),
        .mst_rst_n (mst_rst_n),
        .part_rst_n(part_rst_n),
        .mode_sel  (mode_sel),
        .wr_en_n   (wr_en_n),
        .rgray_s   (rgray_s),
        .waddr     (waddr_w),
        .we        (we_w),
        .wgray     (wgray_w),
        .wr_flag   (wr_flag),
        .mode      (wr_mode_w)
    );

    tcf_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_rd (
        .clk       (rd_clk),
        .mst_rst_n (mst_rst_n),
        .part_rst_n(part_rst_n),
        .mode_sel  (mode_sel),
        .rd_en_n   (rd_en_n),
        .rt_n      (rt_n),
        .wgray_s   (wgray_s),
        .mem_rdata (mem_q),
        .raddr     (raddr_r),
        .rgray     (rgray_r),
        .q         (q_r),
        .rd_flag   (rd_flag),
        .mode      (rd_mode_r)
    );

    tcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_w2r (
        .clk  (rd_clk),
        .rst_n(rst_ok),
        .d    (wgray_w),
        .q    (wgray_s)
    );

    tcf_sync #(.W(PW), .STAGES(SYNC_STAGES)) i_r2w (
        .clk  (wr_clk),
        .rst_n(rst_ok),
        .d    (rgray_r),
        .q    (rgray_s)
    );

    assign rd_data     = out_en ? q_r : '0;
    assign rd_data_vld = out_en;
endmodule

// File: rtl/tcf_checker.sv
`timescale 1ns/1ps
// Module: tcf_checker
// Concurrent properties for twin_clock_fifo, attached by bind. Observes the
// flags, the Gray pointers, the output register and the latched modes.
module tcf_checker #(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              mst_rst_n,
    input logic              part_rst_n,
    input logic              wr_en_n,
    input logic              rd_en_n,
    input logic              rt_n,
    input logic              wr_flag,
    input logic              rd_flag,
    input logic              wr_mode,
    input logic              rd_mode,
    input logic [ADDR_W:0]   wgray,
    input logic [ADDR_W:0]   rgray,
    input logic [DATA_W-1:0] q
);
    logic rst_ok;
    logic w_run;
    logic r_run;
    logic w_mrun;
    logic r_mrun;
    logic wfull;

    assign rst_ok = mst_rst_n && part_rst_n;
    assign wfull  = wr_mode ? !wr_flag : wr_flag;

    // Mark write cycles whose previous edge was out of reset.
    always_ff @(posedge wr_clk) begin
        w_run  <= rst_ok;
        w_mrun <= mst_rst_n;
    end

    // Mark read cycles whose previous edge was out of reset.
    always_ff @(posedge rd_clk) begin
        r_run  <= rst_ok;
        r_mrun <= mst_rst_n;
    end

    AST_NO_OVERFLOW: assert property (@(posedge wr_clk) disable iff (!rst_ok)
        (w_run && wfull && !wr_en_n) |=> (wgray == $past(wgray))); // R6

    AST_NO_UNDERFLOW: assert property (@(posedge rd_clk) disable iff (!rst_ok)
        (r_run && !rd_mode && rd_flag && !rd_en_n && rt_n) |=> ($stable(q) && $stable(rgray))); // R7

    AST_WGRAY_STEP: assert property (@(posedge wr_clk) disable iff (!rst_ok)
        w_run |-> ($countones(wgray ^ $past(wgray)) <= 1)); // R1

    AST_RGRAY_STEP: assert property (@(posedge rd_clk) disable iff (!rst_ok)
        (r_run && $past(rt_n)) |-> ($countones(rgray ^ $past(rgray)) <= 1)); // R11

    AST_RD_MODE_HELD: assert property (@(posedge rd_clk) disable iff (!mst_rst_n)
        r_mrun |-> $stable(rd_mode)); // R2

    AST_WR_MODE_HELD: assert property (@(posedge wr_clk) disable iff (!mst_rst_n)
        w_mrun |-> $stable(wr_mode)); // R2

    AST_FALL_HOLD: assert property (@(posedge rd_clk) disable iff (!rst_ok)
        (r_run && rd_mode && rd_flag && rd_en_n && rt_n) |=> (rd_flag && $stable(q))); // R5

    AST_RT_BLANK: assert property (@(posedge rd_clk) disable iff (!rst_ok)
        (r_run && !rt_n) |=> (rd_mode ? !rd_flag : rd_flag)); // R9
endmodule

bind twin_clock_fifo tcf_checker #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_tcf_checker (
    .wr_clk    (wr_clk),
    .rd_clk    (rd_clk),
    .mst_rst_n (mst_rst_n),
    .part_rst_n(part_rst_n),
    .wr_en_n   (wr_en_n),
    .rd_en_n   (rd_en_n),
    .rt_n      (rt_n),
    .wr_flag   (wr_flag),
    .rd_flag   (rd_flag),
    .wr_mode   (wr_mode_w),
    .rd_mode   (rd_mode_r),
    .wgray     (wgray_w),
    .rgray     (rgray_r),
    .q         (q_r)
);

// File: tb/test_twin_clock_fifo.sv
`timescale 1ns/100ps
// Directed bench for twin_clock_fifo: write clock 250 MHz, read clock with
// a 6 ns period, edges never coincident.
module test_twin_clock_fifo;
    localparam int DW    = 18;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          mst_rst_n = 1'b0;
    logic          part_rst_n = 1'b1;
    logic          mode_sel = 1'b0;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          rt_n = 1'b1;
    logic          out_en = 1'b1;
    logic [DW-1:0] rd_data;
    logic          rd_data_vld;
    logic          wr_flag;
    logic          rd_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #2 wr_clk = ~wr_clk;
    always #3 rd_clk = ~rd_clk;

    twin_clock_fifo #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) i_twin_clock_fifo (
        .wr_clk(wr_clk), .rd_clk(rd_clk), .mst_rst_n(mst_rst_n), .part_rst_n(part_rst_n),
        .mode_sel(mode_sel), .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
        .rt_n(rt_n), .out_en(out_en), .rd_data(rd_data), .rd_data_vld(rd_data_vld),
        .wr_flag(wr_flag), .rd_flag(rd_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic settle_rd(input int n);
        repeat (n) @(posedge rd_clk);
        #0.2;
    endtask

    task automatic settle_wr(input int n);
        repeat (n) @(posedge wr_clk);
        #0.2;
    endtask

    task automatic master_reset(input logic m);
        @(negedge wr_clk);
        mst_rst_n = 1'b0;
        mode_sel  = m;
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk);
        mst_rst_n = 1'b1;
        settle_rd(3);
    endtask

    task automatic partial_reset();
        @(negedge wr_clk);
        part_rst_n = 1'b0;
        repeat (4) @(posedge rd_clk);
        @(negedge wr_clk);
        part_rst_n = 1'b1;
        settle_rd(3);
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wr_clk);
        wr_en_n = 1'b0;
        wr_data = d;
        @(posedge wr_clk);
        #0.2;
        wr_en_n = 1'b1;
    endtask

    task automatic pull(output logic [DW-1:0] d);
        @(negedge rd_clk);
        rd_en_n = 1'b0;
        @(posedge rd_clk);
        #0.2;
        rd_en_n = 1'b1;
        d = rd_data;
    endtask

    task automatic rewind();
        @(negedge rd_clk);
        rt_n = 1'b0;
        @(posedge rd_clk);
        #0.2;
        rt_n = 1'b1;
    endtask

    // Reset state in standard timing.
    task automatic t_reset_std();
        master_reset(1'b0);
        chk("R8 reset rd_data", rd_data, 0);
        chk("R3 reset empty", rd_flag, 1);
        chk("R3 reset not full", wr_flag, 0);
        chk("R10 reset vld", rd_data_vld, 1);
    endtask

    // First word needs an explicit read; an empty read is then ignored.
    task automatic t_std_first();
        logic [DW-1:0] d;
        push(18'h1A5A5);
        settle_rd(4);
        chk("R3 not empty", rd_flag, 0);
        chk("R3 output untouched", rd_data, 0);
        pull(d);
        chk("R1 read word", d, 18'h1A5A5);
        chk("R7 empty after read", rd_flag, 1);
        pull(d);
        chk("R7 empty read ignored", d, 18'h1A5A5);
    endtask

    // Fill to depth, overfill, drain in order.
    task automatic t_std_full();
        logic [DW-1:0] d;
        for (int i = 0; i < DEPTH; i++) push(DW'(32'h100 + i));
        chk("R12 full at depth", wr_flag, 1);
        push(18'h3FFFF);
        chk("R6 still full", wr_flag, 1);
        settle_rd(4);
        for (int i = 0; i < DEPTH; i++) begin
            pull(d);
            chk("R11 order", d, 32'h100 + i);
        end
        chk("R6 extra word dropped", rd_flag, 1);
        settle_wr(4);
        chk("R12 full clears", wr_flag, 0);
    endtask

    // Output enable gating.
    task automatic t_oe();
        @(negedge rd_clk);
        out_en = 1'b0;
        #0.5;
        chk("R10 idle data", rd_data, 0);
        chk("R10 idle vld", rd_data_vld, 0);
        out_en = 1'b1;
        #0.5;
        chk("R10 restored data", rd_data, 32'h10F);
        chk("R10 restored vld", rd_data_vld, 1);
    endtask

    // Partial reset keeps standard timing; rewind replays data.
    task automatic t_std_rt();
        logic [DW-1:0] d;
        partial_reset();
        chk("R8 partial clears q", rd_data, 0);
        chk("R8 partial empty", rd_flag, 1);
        push(18'h2A001);
        push(18'h2A002);
        push(18'h2A003);
        settle_rd(4);
        chk("R8 standard kept", rd_data, 0);
        pull(d);
        chk("R9 pre word0", d, 18'h2A001);
        pull(d);
        chk("R9 pre word1", d, 18'h2A002);
        rewind();
        chk("R9 blank empty", rd_flag, 1);
        settle_rd(1);
        chk("R9 blank ends", rd_flag, 0);
        pull(d);
        chk("R9 replay word0", d, 18'h2A001);
        pull(d);
        chk("R9 replay word1", d, 18'h2A002);
        pull(d);
        chk("R9 replay word2", d, 18'h2A003);
        chk("R9 write ptr kept", rd_flag, 1);
    endtask

    // Fall-through reset, latency, hold and step.
    task automatic t_fall();
        logic [DW-1:0] d;
        master_reset(1'b1);
        mode_sel = 1'b0;
        chk("R8 fall reset data", rd_data, 0);
        chk("R4 no valid output", rd_flag, 0);
        chk("R4 input ready", wr_flag, 1);
        push(18'h15555);
        settle_rd(2);
        chk("R4 not yet at edge 2", rd_flag, 0);
        settle_rd(1);
        chk("R4 valid at edge 3", rd_flag, 1);
        chk("R4 word shown", rd_data, 18'h15555);
        chk("R2 mode_sel change ignored", rd_data, 18'h15555);
        push(18'h0AAAA);
        push(18'h12345);
        settle_rd(4);
        chk("R5 held without read", rd_data, 18'h15555);
        pull(d);
        chk("R5 next word", d, 18'h0AAAA);
        rewind();
        chk("R9 fall blank", rd_flag, 0);
        settle_rd(2);
        chk("R9 fall refilled", rd_flag, 1);
        chk("R9 fall replay word0", rd_data, 18'h15555);
        pull(d);
        chk("R9 fall replay word1", d, 18'h0AAAA);
        pull(d);
        chk("R5 third word", d, 18'h12345);
        pull(d);
        chk("R5 drained", rd_flag, 0);
    endtask

    // Partial reset keeps fall-through timing.
    task automatic t_fall_partial();
        partial_reset();
        chk("R8 fall partial data", rd_data, 0);
        chk("R8 fall partial flag", rd_flag, 0);
        chk("R8 fall kept ready", wr_flag, 1);
        push(18'h3C3C3);
        settle_rd(3);
        chk("R8 fall-through kept", rd_flag, 1);
        chk("R8 fall-through word", rd_data, 18'h3C3C3);
    endtask

    initial begin
        t_reset_std();
        t_std_first();
        t_std_full();
        t_oe();
        t_std_rt();
        t_fall();
        t_fall_partial();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule